// File: doc/BRIEF.md
# Second-Level Cache Control Register with Flush Walker

This block is a single supervisor-only control and status register for a second-level cache, with a sequencer that flushes the whole cache. The core reaches the register through its alternate-address-space load/store port. The register is selected only at space identifier 0x6A and virtual address 0x10. A read returns a sticky error-trap flag and the configured associativity. A write can clear the flag or start a flush.

The flag is set by any of three error pulses from the core: instruction access error, data access error and asynchronous data error. It stays set until software writes a 1 to its bit.

Writing a 1 to the command bit starts a walk over every line of the cache. For each line the walker reads the dirty indication from the cache array. If the line is dirty it requests a writeback and waits for the acknowledge. It then invalidates the line. The stall output holds the core for the whole walk. The cache arrays and the memory side are represented only by their request and acknowledge signals.

Top module: `cache_ctl_csr`

## Requirements
- R1: Only an access with space identifier 0x6A and address 0x10 selects the register. Any other access gets no read response and changes no state.
- R2: A user-mode access (`acc_super`=0) to the register is not performed. It produces no read response and raises `priv_fault` for exactly the one cycle after the access.
- R3: Bit 24 of the register is set, one cycle after the event, by a pulse on any of `err_iae`, `err_dae` or `err_async`.
- R4: Bit 24 stays set until a supervisor write with data bit 24 = 1. A write with data bit 24 = 0 leaves it unchanged.
- R5: When an error pulse and a write-1 clear of bit 24 arrive in the same cycle, bit 24 is set afterwards.
- R6: Bits 18:16 always read as the associativity parameter, which is 2 or 4. Writes to these bits are ignored.
- R7: All other bits, including bits 63:25, 23:19, 15:1 and the command bit 0, read as zero whatever was written.
- R8: A supervisor write with data bit 0 = 1 starts a flush. `core_stall` is high from the cycle after that write until the cycle of the last invalidate, and low again one cycle later.
- R9: The flush invalidates every line exactly once (one `inv_req` cycle per line). It visits sets in ascending order, and ways in ascending order within each set.
- R10: For a line with `line_dirty`=1, `wb_req` is raised and held, with the line address stable, until `wb_ack`. The invalidate follows the acknowledge. For a clean line, no `wb_req` is raised.
- R11: A flush command issued while a flush is running is ignored. No second walk follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Alternate-space access valid this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_asi | input | 8 | Address space identifier of the access |
| acc_addr | input | ADDR_W | Virtual address of the access |
| acc_super | input | 1 | Access is made in supervisor mode |
| acc_wdata | input | 64 | Store data |
| rd_valid | output | 1 | Read response valid (one cycle after the load) |
| rd_data | output | 64 | Read response data |
| priv_fault | output | 1 | User-mode access to the register was refused |
| err_iae | input | 1 | Instruction access error event pulse |
| err_dae | input | 1 | Data access error event pulse |
| err_async | input | 1 | Asynchronous data error event pulse |
| core_stall | output | 1 | Holds the core while a flush runs |
| walk_set | output | SET_W | Set index of the line being flushed |
| walk_way | output | WAY_W | Way index of the line being flushed |
| line_dirty | input | 1 | Dirty indication of the addressed line from the array |
| wb_req | output | 1 | Writeback request for the addressed line |
| wb_ack | input | 1 | Writeback acknowledge |
| inv_req | output | 1 | Invalidate the addressed line this cycle |

## Verification
The checker watches, on every cycle, the rules that hold at any moment. These are: a response must come from a selected access, the associativity and reserved bits read back correctly, the flag is sticky against everything but a clear, an event sets the flag, a pending writeback holds its request and address, and invalidates happen only while the core is stalled. The bench scenarios show the rest, which needs a whole sequence to be seen. That covers the order in which lines are visited, the one-to-one match between dirty lines and writebacks, the event-beats-clear collision, refused user-mode accesses leaving state untouched, and a second flush command during a walk producing no second walk.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
    localparam logic [7:0]  CSR_ASI   = 8'h6A;
    localparam logic [63:0] CSR_VA    = 64'h10;
    localparam int          FLAG_BIT  = 24;
    localparam int          ASSOC_LO  = 16;
    localparam int          ASSOC_HI  = 18;
    localparam int          FLUSH_BIT = 0;

    typedef enum logic [1:0] {
        WK_IDLE,
        WK_PROBE,
        WK_WBACK,
        WK_INVAL
    } walk_st_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
    parameter int ADDR_W = 64
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [7:0]        acc_asi,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic              wd_flag,
    input  logic              wd_flush,
    output logic              sel_rd,
    output logic              fault,
    output logic              flush_cmd,
    output logic              clr_cmd
);
    import cache_ctl_pkg::*;

    logic hit;
    logic granted;

    always_comb begin
        hit       = acc_valid && (acc_asi == CSR_ASI) && (acc_addr == ADDR_W'(CSR_VA));
        granted   = hit && acc_super;
        fault     = hit && !acc_super;
        sel_rd    = granted && !acc_write;
        flush_cmd = granted && acc_write && wd_flush;
        clr_cmd   = granted && acc_write && wd_flag;
    end
endmodule

// File: rtl/err_flag.sv
module err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_iae,
    input  logic ev_dae,
    input  logic ev_async,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic flag;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_iae || ev_dae || ev_async) begin
            st_d.flag = 1'b1;
        end else if (clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;
endmodule

// File: rtl/flush_walker.sv
module flush_walker #(
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             line_dirty,
    input  logic             wb_ack,
    output logic             busy,
    output logic [SET_W-1:0] walk_set,
    output logic [WAY_W-1:0] walk_way,
    output logic             wb_req,
    output logic             inv_req
);
    import cache_ctl_pkg::*;

    localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);
    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(WAYS - 1);

    typedef struct packed {
        walk_st_e         st;
        logic [SET_W-1:0] set;
        logic [WAY_W-1:0] way;
    } walk_s;

    walk_s wk_d, wk_q;

    always_comb begin
        wk_d = wk_q;
        unique case (wk_q.st)
            WK_IDLE: begin
                if (start) begin
                    wk_d.st  = WK_PROBE;
                    wk_d.set = '0;
                    wk_d.way = '0;
                end
            end
            WK_PROBE: begin
                wk_d.st = line_dirty ? WK_WBACK : WK_INVAL;
            end
            WK_WBACK: begin
                if (wb_ack) begin
                    wk_d.st = WK_INVAL;
                end
            end
            WK_INVAL: begin
                if (wk_q.way == LAST_WAY) begin
                    wk_d.way = '0;
                    if (wk_q.set == LAST_SET) begin
                        wk_d.st  = WK_IDLE;
                        wk_d.set = '0;
                    end else begin
                        wk_d.st  = WK_PROBE;
                        wk_d.set = wk_q.set + 1'b1;
                    end
                end else begin
                    wk_d.st  = WK_PROBE;
                    wk_d.way = wk_q.way + 1'b1;
                end
            end
            default: wk_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q <= '{st: WK_IDLE, set: '0, way: '0};
        end else begin
            wk_q <= wk_d;
        end
    end

    assign busy     = (wk_q.st != WK_IDLE);
    assign wb_req   = (wk_q.st == WK_WBACK);
    assign inv_req  = (wk_q.st == WK_INVAL);
    assign walk_set = wk_q.set;
    assign walk_way = wk_q.way;
endmodule

// File: rtl/cache_ctl_csr.sv
module cache_ctl_csr #(
    parameter int ADDR_W   = 64,
    parameter int NUM_SETS = 8,
    parameter int WAYS     = 4,
    localparam int SET_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
    localparam int WAY_W   = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [7:0]        acc_asi,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_super,
    input  logic [63:0]       acc_wdata,
    output logic              rd_valid,
    output logic [63:0]       rd_data,
    output logic              priv_fault,
    input  logic              err_iae,
    input  logic              err_dae,
    input  logic              err_async,
    output logic              core_stall,
    output logic [SET_W-1:0]  walk_set,
    output logic [WAY_W-1:0]  walk_way,
    input  logic              line_dirty,
    output logic              wb_req,
    input  logic              wb_ack,
    output logic              inv_req
);
    import cache_ctl_pkg::*;

    if (WAYS != 2 && WAYS != 4) begin : g_bad_ways
        $error("cache_ctl_csr: WAYS must be 2 or 4");
    end

    logic sel_rd, fault, flush_cmd, clr_cmd, flag_q;

    csr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_asi   (acc_asi),
        .acc_addr  (acc_addr),
        .acc_super (acc_super),
        .wd_flag   (acc_wdata[FLAG_BIT]),
        .wd_flush  (acc_wdata[FLUSH_BIT]),
        .sel_rd    (sel_rd),
        .fault     (fault),
        .flush_cmd (flush_cmd),
        .clr_cmd   (clr_cmd)
    );

    err_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_iae   (err_iae),
        .ev_dae   (err_dae),
        .ev_async (err_async),
        .clr      (clr_cmd),
        .flag     (flag_q)
    );

    flush_walker #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_walk (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (flush_cmd),
        .line_dirty (line_dirty),
        .wb_ack     (wb_ack),
        .busy       (core_stall),
        .walk_set   (walk_set),
        .walk_way   (walk_way),
        .wb_req     (wb_req),
        .inv_req    (inv_req)
    );

    typedef struct packed {
        logic        rd_valid;
        logic [63:0] rd_data;
        logic        fault;
    } rsp_s;

    rsp_s rsp_d, rsp_q;
    logic [63:0] rd_word;

    always_comb begin
        rd_word                     = '0;
        rd_word[FLAG_BIT]           = flag_q;
        rd_word[ASSOC_HI:ASSOC_LO]  = 3'(WAYS);
        rsp_d.rd_valid = sel_rd;
        rsp_d.rd_data  = sel_rd ? rd_word : '0;
        rsp_d.fault    = fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rd_valid   = rsp_q.rd_valid;
    assign rd_data    = rsp_q.rd_data;
    assign priv_fault = rsp_q.fault;
endmodule

// File: rtl/cache_ctl_csr_chk.sv
module cache_ctl_csr_chk #(
    parameter int ADDR_W = 64,
    parameter int WAYS   = 4,
    parameter int SET_W  = 3,
    parameter int WAY_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [7:0]        acc_asi,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              err_any,
    input logic              clr,
    input logic              flag,
    input logic              rd_valid,
    input logic [63:0]       rd_data,
    input logic              priv_fault,
    input logic              core_stall,
    input logic [SET_W-1:0]  walk_set,
    input logic [WAY_W-1:0]  walk_way,
    input logic              wb_req,
    input logic              wb_ack,
    input logic              inv_req
);
    localparam logic [63:0] KEEP = 64'h0000_0000_0107_0000;

    assert_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && acc_asi == 8'h6A && acc_addr == ADDR_W'(64'h10)));

    assert_fault_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> !rd_valid);

    assert_event_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> flag);

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    assert_assoc_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data[18:16] == 3'(WAYS)));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~KEEP) == 64'h0));

    assert_inv_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inv_req |-> core_stall);

    assert_wb_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(walk_set) && $stable(walk_way)));

    assert_wb_inv_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_req && inv_req));
endmodule

bind cache_ctl_csr cache_ctl_csr_chk #(
    .ADDR_W (ADDR_W),
    .WAYS   (WAYS),
    .SET_W  (SET_W),
    .WAY_W  (WAY_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_asi    (acc_asi),
    .acc_addr   (acc_addr),
    .err_any    (err_iae | err_dae | err_async),
    .clr        (clr_cmd),
    .flag       (flag_q),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .priv_fault (priv_fault),
    .core_stall (core_stall),
    .walk_set   (walk_set),
    .walk_way   (walk_way),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .inv_req    (inv_req)
);

// File: tb/cache_ctl_csr_tb.sv
module cache_ctl_csr_tb;
    localparam int ADDR_W   = 64;
    localparam int NUM_SETS = 8;
    localparam int WAYS     = 4;
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int WAY_W    = $clog2(WAYS);
    localparam int LINES    = NUM_SETS * WAYS;
    localparam logic [7:0]        ASI = 8'h6A;
    localparam logic [ADDR_W-1:0] VA  = 64'h10;
    localparam logic [63:0] ASSOC_WORD = 64'(WAYS) << 16;
    localparam logic [63:0] FLAG_WORD  = 64'h1 << 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0, acc_super = 1'b0;
    logic [7:0] acc_asi = '0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic err_iae = 1'b0, err_dae = 1'b0, err_async = 1'b0;
    logic wb_ack = 1'b0;
    logic rd_valid, priv_fault, core_stall, wb_req, inv_req, line_dirty;
    logic [63:0] rd_data;
    logic [SET_W-1:0] walk_set;
    logic [WAY_W-1:0] walk_way;

    int n_checks = 0;
    int n_fail = 0;
    int n_inv = 0;
    bit wb_seen = 1'b0;

    logic [63:0] exp_rd[$];
    string       exp_tag[$];
    int          exp_line[$];

    always #5 clk = ~clk;

    function automatic bit dirty_of(int s, int w);
        return ((s + w) % 3) == 0;
    endfunction

    assign line_dirty = dirty_of(int'(walk_set), int'(walk_way));

    cache_ctl_csr #(.ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_asi(acc_asi),
        .acc_addr(acc_addr), .acc_super(acc_super), .acc_wdata(acc_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .priv_fault(priv_fault),
        .err_iae(err_iae), .err_dae(err_dae), .err_async(err_async),
        .core_stall(core_stall), .walk_set(walk_set), .walk_way(walk_way),
        .line_dirty(line_dirty), .wb_req(wb_req), .wb_ack(wb_ack), .inv_req(inv_req)
    );

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // writeback acknowledge model: two cycles after the request appears
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (wb_req && !wb_ack) begin
                wait_cnt++;
                if (wait_cnt == 2) begin
                    wb_ack = 1'b1;
                    wait_cnt = 0;
                end
            end else begin
                wb_ack = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        if (wb_req && wb_ack) wb_seen <= 1'b1;
    end

    // monitor: pops scoreboard entries as responses and invalidates appear
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_rd.size() == 0) begin
                check(1'b0, "R1 unexpected read response", rd_data, 64'h0);
            end else begin
                logic [63:0] e;
                string t;
                e = exp_rd.pop_front();
                t = exp_tag.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
        if (rst_n && inv_req) begin
            int got;
            got = int'(walk_set) * WAYS + int'(walk_way);
            n_inv++;
            if (exp_line.size() == 0) begin
                check(1'b0, "R11 extra invalidate", 64'(got), 64'hFFFF);
            end else begin
                int e;
                e = exp_line.pop_front();
                check(got == e, "R9 line order", 64'(got), 64'(e));
            end
            check(core_stall, "R8 stall during invalidate", 64'(core_stall), 64'h1);
            check(wb_seen == dirty_of(int'(walk_set), int'(walk_way)),
                  "R10 writeback matches dirty", 64'(wb_seen),
                  64'(dirty_of(int'(walk_set), int'(walk_way))));
            wb_seen = 1'b0;
        end
    end

    task automatic access(bit wr, logic [7:0] asi, logic [ADDR_W-1:0] addr, bit sup,
                          logic [63:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_asi = asi;
        acc_addr = addr; acc_super = sup; acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
    endtask

    task automatic rd_expect(logic [63:0] e, string tag);
        exp_rd.push_back(e);
        exp_tag.push_back(tag);
        access(1'b0, ASI, VA, 1'b1, '0);
    endtask

    task automatic pulse_err(bit i, bit d, bit a, bit clr);
        @(negedge clk);
        err_iae = i; err_dae = d; err_async = a;
        if (clr) begin
            acc_valid = 1'b1; acc_write = 1'b1; acc_asi = ASI;
            acc_addr = VA; acc_super = 1'b1; acc_wdata = FLAG_WORD;
        end
        @(negedge clk);
        err_iae = 1'b0; err_dae = 1'b0; err_async = 1'b0;
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(!core_stall && !rd_valid && !priv_fault && !wb_req && !inv_req,
              "reset outputs idle", {core_stall, rd_valid, priv_fault}, 64'h0);
        rd_expect(ASSOC_WORD, "R6 reset value");

        // R1: wrong identifiers are not selected
        access(1'b0, 8'h6B, VA, 1'b1, '0);
        check(!rd_valid, "R1 wrong ASI no response", 64'(rd_valid), 64'h0);
        access(1'b0, ASI, 64'h18, 1'b1, '0);
        check(!rd_valid, "R1 wrong VA no response", 64'(rd_valid), 64'h0);

        // R3 each event
        pulse_err(1, 0, 0, 0);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R3 iae sets flag");
        // R1 write-1 at wrong VA does not clear
        access(1'b1, ASI, 64'h8, 1'b1, FLAG_WORD);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R1 wrong VA write ignored");
        // R2 user-mode clear refused
        access(1'b1, ASI, VA, 1'b0, FLAG_WORD);
        check(priv_fault && !rd_valid, "R2 user write faults", 64'(priv_fault), 64'h1);
        @(negedge clk);
        check(!priv_fault, "R2 fault lasts one cycle", 64'(priv_fault), 64'h0);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R2 user write not performed");
        access(1'b0, ASI, VA, 1'b0, '0);
        check(priv_fault && !rd_valid, "R2 user read faults", {priv_fault, rd_valid}, 64'h2);
        // R4 write 0 no effect, write 1 clears
        access(1'b1, ASI, VA, 1'b1, 64'h0);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R4 write 0 keeps flag");
        access(1'b1, ASI, VA, 1'b1, FLAG_WORD);
        rd_expect(ASSOC_WORD, "R4 write 1 clears flag");
        pulse_err(0, 1, 0, 0);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R3 dae sets flag");
        // R6 R7: write all ones except command bit; flag clears, fields unchanged
        access(1'b1, ASI, VA, 1'b1, ~64'h1);
        rd_expect(ASSOC_WORD, "R6 R7 fields ignore writes");
        pulse_err(0, 0, 1, 0);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R3 async sets flag");
        access(1'b1, ASI, VA, 1'b1, FLAG_WORD);
        // R5 event and clear together
        pulse_err(1, 0, 0, 1);
        rd_expect(ASSOC_WORD | FLAG_WORD, "R5 event beats clear");
        access(1'b1, ASI, VA, 1'b1, FLAG_WORD);

        // R2: user-mode flush command refused
        access(1'b1, ASI, VA, 1'b0, 64'h1);
        check(!core_stall, "R2 user flush refused", 64'(core_stall), 64'h0);

        // R8 R9 R10 R11: full flush with a repeated command mid-walk
        for (int k = 0; k < LINES; k++) exp_line.push_back(k);
        n_inv = 0;
        access(1'b1, ASI, VA, 1'b1, 64'h1);
        check(core_stall, "R8 stall after flush write", 64'(core_stall), 64'h1);
        rd_expect(ASSOC_WORD, "R7 command bit reads zero");
        repeat (4) @(negedge clk);
        access(1'b1, ASI, VA, 1'b1, 64'h1);
        begin
            int guard = 0;
            while (core_stall && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
        end
        check(!core_stall, "R8 stall released", 64'(core_stall), 64'h0);
        check(exp_line.size() == 0, "R9 every line visited", 64'(exp_line.size()), 64'h0);
        check(n_inv == LINES, "R9 invalidate count", 64'(n_inv), 64'(LINES));
        repeat (20) @(negedge clk);
        check(!core_stall && n_inv == LINES, "R11 second command ignored",
              64'(n_inv), 64'(LINES));
        check(exp_rd.size() == 0, "R1 all responses seen", 64'(exp_rd.size()), 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule